// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Port

This block is a single memory port shared by several requesting cores. Each requester raises a valid line together with an opcode, a word address and up to two operands. It keeps them steady until it receives its own done pulse. A round-robin arbiter hands the port to one requester at a time. The unit then runs a plain load, a plain store, or one of three indivisible read-modify-write operations on a small internal word array: test-and-set, fetch-and-add and compare-and-swap.

Every atomic operation takes a read cycle and then a write cycle. Across both cycles the unit raises a bus lock, and no other requester can be granted until the operation finishes. A failed test-and-set or a mismatched compare-and-swap still takes both cycles, but it leaves memory untouched. Software can build a spin lock from these operations. Test-and-set takes the lock, and a plain store of zero releases it.

Top module: `atomic_mem_port`

## Requirements
- R1: After reset every word of the array reads 0, no done bit is high and bus_lock is low.
- R2: A load (opcode 0) returns the addressed word on rsp_data and leaves memory unchanged. Opcodes 5 to 7 behave as a load. rsp_flag is 0 for loads.
- R3: A store (opcode 1) writes operand A in a single access cycle without raising bus_lock. rsp_data returns the word held before the store. A store of 0 frees a word that test-and-set had set.
- R4: Test-and-set (opcode 2) on a word holding 0 writes 1 and returns rsp_flag = 1.
- R5: Test-and-set on a nonzero word returns rsp_flag = 0 and leaves the word unchanged.
- R6: Fetch-and-add (opcode 3) returns the old word and writes old + A, wrapping modulo 2^DATA_W. rsp_flag is 0.
- R7: Compare-and-swap (opcode 4) writes operand B and returns rsp_flag = 1 when the word equals operand A.
- R8: Compare-and-swap on a word different from operand A returns rsp_flag = 0 and writes nothing.
- R9: For an atomic operation, bus_lock is high for exactly the read cycle and the write cycle. Done follows directly after those cycles, and the grant does not change while the lock is held.
- R10: Grants rotate round-robin. After requester i is served, the search starts at i+1, and after reset it starts at requester 0.
- R11: Completion is a one-cycle pulse on rsp_done for the served requester only. rsp_data and rsp_flag are valid in that cycle.
- R12: When several requesters issue test-and-set on the same zero word at once, exactly one of them sees rsp_flag = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Request valid, one bit per requester, held until that requester's done |
| req_op | input | N_REQ*3 | Opcode per requester: 0 load, 1 store, 2 test-and-set, 3 fetch-and-add, 4 compare-and-swap |
| req_addr | input | N_REQ*ADDR_W | Word address per requester |
| req_opa | input | N_REQ*DATA_W | Operand A: store data, increment or compare value |
| req_opb | input | N_REQ*DATA_W | Operand B: swap value for compare-and-swap |
| rsp_done | output | N_REQ | One-cycle completion pulse to the served requester |
| rsp_data | output | DATA_W | Word read by the finished operation (value before any write) |
| rsp_flag | output | 1 | Zero flag of test-and-set or success of compare-and-swap |
| bus_lock | output | 1 | High while an atomic operation owns the memory between read and write |

## Verification
Suppose an idle unit accepts a request at clock edge k. A load or store raises done after edge k+1, with the store's write landing at that same edge. An atomic operation raises bus_lock after edge k, writes at edge k+2 and raises done after edge k+2. The next grant is taken at the edge after done ends. The bench runs a behavioural model that advances on the same rising edge as the design, and it compares done, lock, data and flag at every falling edge. Every result is therefore checked in the exact cycle it is due, and a late or early result is never accepted.

// File: rtl/atom_pkg.sv
package atom_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_TAS   = 3'd2,
    OP_FAA   = 3'd3,
    OP_CAS   = 3'd4
  } atom_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_WRITE  = 2'd2,
    ST_DONE   = 2'd3
  } port_state_e;

  function automatic logic op_is_rmw(input atom_op_e op);
    return (op == OP_TAS) || (op == OP_FAA) || (op == OP_CAS);
  endfunction

endpackage

// File: rtl/atom_rr_arb.sv
module atom_rr_arb #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  input  logic             take,
  output logic             any,
  output logic [IDX_W-1:0] pick
);

  logic [IDX_W-1:0] last_q;

  always_comb begin
    int idx_i;
    logic [IDX_W-1:0] idx_l;
    any  = 1'b0;
    pick = '0;
    for (int k = 1; k <= N_REQ; k++) begin
      idx_i = int'(last_q) + k;
      if (idx_i >= N_REQ) idx_i = idx_i - N_REQ;
      idx_l = IDX_W'(idx_i);
      if (!any && req[idx_l]) begin
        any  = 1'b1;
        pick = idx_l;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IDX_W'(N_REQ - 1);
    else if (take) last_q <= pick;
  end

  // R10
  arb_pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> req[pick]);

  // R10
  arb_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(last_q));

endmodule

// File: rtl/atom_rmw_calc.sv
module atom_rmw_calc
  import atom_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  atom_op_e          op,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              wr,
  output logic [DATA_W-1:0] wdata,
  output logic              flag
);

  function automatic logic tas_hit(input logic [DATA_W-1:0] w);
    return (w == '0);
  endfunction

  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] w,
                                                 input logic [DATA_W-1:0] inc);
    return w + inc;
  endfunction

  function automatic logic cas_hit(input logic [DATA_W-1:0] w,
                                   input logic [DATA_W-1:0] cmp);
    return (w == cmp);
  endfunction

  always_comb begin
    wr    = 1'b0;
    wdata = '0;
    flag  = 1'b0;
    unique case (op)
      OP_STORE: begin
        wr    = 1'b1;
        wdata = opa;
      end
      OP_TAS: begin
        wr    = tas_hit(old_word);
        wdata = DATA_W'(1);
        flag  = tas_hit(old_word);
      end
      OP_FAA: begin
        wr    = 1'b1;
        wdata = add_wrap(old_word, opa);
      end
      OP_CAS: begin
        wr    = cas_hit(old_word, opa);
        wdata = opb;
        flag  = cas_hit(old_word, opa);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/atom_word_store.sv
module atom_word_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) words[w] <= '0;
    end else if (we) begin
      words[addr] <= wdata;
    end
  end

  assign rdata = words[addr];

endmodule

// File: rtl/atomic_mem_port.sv
module atomic_mem_port
  import atom_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_REQ-1:0]         req_valid,
  input  logic [N_REQ*OP_W-1:0]    req_op,
  input  logic [N_REQ*ADDR_W-1:0]  req_addr,
  input  logic [N_REQ*DATA_W-1:0]  req_opa,
  input  logic [N_REQ*DATA_W-1:0]  req_opb,
  output logic [N_REQ-1:0]         rsp_done,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     rsp_flag,
  output logic                     bus_lock
);

  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [OP_W-1:0]   op_arr   [N_REQ];
  logic [ADDR_W-1:0] addr_arr [N_REQ];
  logic [DATA_W-1:0] opa_arr  [N_REQ];
  logic [DATA_W-1:0] opb_arr  [N_REQ];

  for (genvar i = 0; i < N_REQ; i++) begin : g_unpack
    assign op_arr[i]   = req_op[i*OP_W +: OP_W];
    assign addr_arr[i] = req_addr[i*ADDR_W +: ADDR_W];
    assign opa_arr[i]  = req_opa[i*DATA_W +: DATA_W];
    assign opb_arr[i]  = req_opb[i*DATA_W +: DATA_W];
  end

  port_state_e       st_q;
  logic [IDX_W-1:0]  gnt_q;
  atom_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opa_q, opb_q, old_q;
  logic [DATA_W-1:0] data_q;
  logic              flag_q;

  // named internal events
  logic              arb_any;
  logic [IDX_W-1:0]  arb_pick;
  logic              take;
  logic              acc_fire;
  logic              wr_fire;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] calc_old;
  logic              calc_wr;
  logic [DATA_W-1:0] calc_wdata;
  logic              calc_flag;

  assign take     = (st_q == ST_IDLE) && arb_any;
  assign acc_fire = (st_q == ST_ACCESS);
  assign wr_fire  = (st_q == ST_WRITE);

  atom_rr_arb #(.N_REQ(N_REQ)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req_valid),
    .take (take),
    .any  (arb_any),
    .pick (arb_pick)
  );

  assign calc_old = wr_fire ? old_q : mem_rdata;

  atom_rmw_calc #(.DATA_W(DATA_W)) u_calc (
    .op      (op_q),
    .old_word(calc_old),
    .opa     (opa_q),
    .opb     (opb_q),
    .wr      (calc_wr),
    .wdata   (calc_wdata),
    .flag    (calc_flag)
  );

  assign mem_we = (acc_fire && (op_q == OP_STORE)) || (wr_fire && calc_wr);

  atom_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (addr_q),
    .we   (mem_we),
    .wdata(calc_wdata),
    .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      gnt_q  <= '0;
      op_q   <= OP_LOAD;
      addr_q <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      old_q  <= '0;
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (take) begin
            gnt_q  <= arb_pick;
            op_q   <= atom_op_e'(op_arr[arb_pick]);
            addr_q <= addr_arr[arb_pick];
            opa_q  <= opa_arr[arb_pick];
            opb_q  <= opb_arr[arb_pick];
            st_q   <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          old_q  <= mem_rdata;
          data_q <= mem_rdata;
          flag_q <= calc_flag;
          st_q   <= op_is_rmw(op_q) ? ST_WRITE : ST_DONE;
        end
        ST_WRITE: st_q <= ST_DONE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < N_REQ; i++) begin : g_done
    assign rsp_done[i] = (st_q == ST_DONE) && (gnt_q == IDX_W'(i));
  end

  assign rsp_data = data_q;
  assign rsp_flag = flag_q;
  assign bus_lock = (acc_fire && op_is_rmw(op_q)) || wr_fire;

  // R11
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_done));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_done) |=> !(|rsp_done));

  // R9
  lock_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |=> bus_lock);

  // R9
  lock_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock |=> (bus_lock || (|rsp_done)));

  // R9
  lock_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock |=> $stable(gnt_q));

  // R9
  no_grant_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !bus_lock);

  // R5
  tas_fail_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && op_q == OP_TAS && old_q != '0) |-> !mem_we);

  // R8
  cas_miss_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && op_q == OP_CAS && old_q != opa_q) |-> !mem_we);

  // R3
  store_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && op_q == OP_STORE) |-> (mem_we && !bus_lock));

  // R2
  load_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_LOAD) |-> !mem_we);

endmodule

// File: tb/atomic_mem_port_test.sv
`timescale 1ns/1ps
module atomic_mem_port_test;

  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    vld = '0;
  logic [N*3-1:0]  req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_opa = '0;
  logic [N*DW-1:0] req_opb = '0;
  logic [N-1:0]    rsp_done;
  logic [DW-1:0]   rsp_data;
  logic            rsp_flag;
  logic            bus_lock;

  always #2.5 clk = ~clk;

  atomic_mem_port #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(vld), .req_op(req_op),
    .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_flag(rsp_flag),
    .bus_lock(bus_lock)
  );

  int n_chk = 0;
  int n_fail = 0;

  // behavioural reference model
  int      m_phase;
  int      m_own;
  int      m_last;
  int      m_op;
  int      m_addr;
  int      m_a, m_b;
  int      m_data;
  int      m_flag;
  int      m_wr;
  int      m_wv;
  int      m_mem [16];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_last = N - 1; m_own = 0; m_op = 0;
      for (int w = 0; w < 16; w++) m_mem[w] = 0;
    end else begin
      case (m_phase)
        0: begin
          int win;
          win = -1;
          for (int k = 1; k <= N; k++) begin
            int c;
            c = (m_last + k) % N;
            if (win < 0 && vld[c]) win = c;
          end
          if (win >= 0) begin
            m_own = win; m_last = win;
            m_op   = int'(req_op[win*3 +: 3]);
            m_addr = int'(req_addr[win*AW +: AW]);
            m_a    = int'(req_opa[win*DW +: DW]);
            m_b    = int'(req_opb[win*DW +: DW]);
            m_phase = 1;
          end
        end
        1: begin
          int old;
          old = m_mem[m_addr];
          m_data = old; m_flag = 0; m_wr = 0; m_wv = 0;
          case (m_op)
            1: m_mem[m_addr] = m_a;
            2: if (old == 0) begin m_flag = 1; m_wr = 1; m_wv = 1; end
            3: begin m_wr = 1; m_wv = (old + m_a) % 65536; end
            4: if (old == m_a) begin m_flag = 1; m_wr = 1; m_wv = m_b; end
            default: ;
          endcase
          m_phase = (m_op >= 2 && m_op <= 4) ? 2 : 3;
        end
        2: begin
          if (m_wr != 0) m_mem[m_addr] = m_wv;
          m_phase = 3;
        end
        default: m_phase = 0;
      endcase
    end
  end

  int      res_data [N];
  int      res_flag [N];
  int      order [$];
  bit      conc_tas = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string op_tag(input int op, input int fl);
    case (op)
      1: return "R3";
      2: return (fl != 0) ? "R4" : "R5";
      3: return "R6";
      4: return (fl != 0) ? "R7" : "R8";
      default: return "R2";
    endcase
  endfunction

  // compare at the falling edge, then release served requesters
  task automatic step();
    logic [N-1:0] e_done;
    bit e_lock;
    @(negedge clk);
    e_done = '0;
    if (m_phase == 3) e_done[m_own] = 1'b1;
    e_lock = (m_phase == 1 && m_op >= 2 && m_op <= 4) || (m_phase == 2);
    chk(rsp_done == e_done, "R11 done", int'(rsp_done), int'(e_done));
    chk(bus_lock == e_lock, "R9 lock", int'(bus_lock), int'(e_lock));
    if (m_phase == 3) begin
      string t;
      t = conc_tas ? "R12" : op_tag(m_op, m_flag);
      chk(int'(rsp_data) == m_data, t, int'(rsp_data), m_data);
      chk(int'(rsp_flag) == m_flag, t, int'(rsp_flag), m_flag);
      res_data[m_own] = int'(rsp_data);
      res_flag[m_own] = int'(rsp_flag);
      order.push_back(m_own);
    end
    for (int i = 0; i < N; i++) if (rsp_done[i]) vld[i] = 1'b0;
  endtask

  task automatic run();
    do step(); while ((|vld) || m_phase != 0);
  endtask

  task automatic issue(input int p, input int op, input int ad, input int a, input int b);
    req_op[p*3 +: 3]    = 3'(op);
    req_addr[p*AW +: AW] = AW'(ad);
    req_opa[p*DW +: DW] = DW'(a);
    req_opb[p*DW +: DW] = DW'(b);
    vld[p] = 1'b1;
  endtask

  task automatic do1(input int p, input int op, input int ad, input int a, input int b);
    issue(p, op, ad, a, b);
    run();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_done == '0, "R1 done", int'(rsp_done), 0);
    chk(bus_lock == 1'b0, "R1 lock", int'(bus_lock), 0);
    do1(0, 0, 0, 0, 0);
    chk(res_data[0] == 0, "R1 word0", res_data[0], 0);
    do1(3, 0, 15, 0, 0);
    chk(res_data[3] == 0, "R1 word15", res_data[3], 0);

    // R3 store then R2 load
    do1(1, 1, 3, 16'h1234, 0);
    do1(2, 0, 3, 0, 0);
    chk(res_data[2] == 16'h1234, "R2 load", res_data[2], 16'h1234);
    do1(2, 6, 3, 0, 0);
    chk(res_data[2] == 16'h1234 && res_flag[2] == 0, "R2 opcode6", res_data[2], 16'h1234);

    // R4 / R5 test-and-set
    do1(0, 2, 7, 0, 0);
    chk(res_flag[0] == 1, "R4 flag", res_flag[0], 1);
    do1(1, 0, 7, 0, 0);
    chk(res_data[1] == 1, "R4 word", res_data[1], 1);
    do1(2, 1, 8, 5, 0);
    do1(3, 2, 8, 0, 0);
    chk(res_flag[3] == 0, "R5 flag", res_flag[3], 0);
    do1(0, 0, 8, 0, 0);
    chk(res_data[0] == 5, "R5 unchanged", res_data[0], 5);

    // R6 fetch-and-add incl. wrap
    do1(2, 3, 3, 5, 0);
    chk(res_data[2] == 16'h1234, "R6 old", res_data[2], 16'h1234);
    do1(2, 0, 3, 0, 0);
    chk(res_data[2] == 16'h1239, "R6 sum", res_data[2], 16'h1239);
    do1(1, 1, 4, 16'hFFFF, 0);
    do1(1, 3, 4, 2, 0);
    do1(1, 0, 4, 0, 0);
    chk(res_data[1] == 1, "R6 wrap", res_data[1], 1);

    // R7 / R8 compare-and-swap
    do1(3, 4, 3, 16'h1239, 16'hBEEF);
    chk(res_flag[3] == 1, "R7 flag", res_flag[3], 1);
    do1(3, 4, 3, 16'h1239, 16'h0042);
    chk(res_flag[3] == 0, "R8 flag", res_flag[3], 0);
    do1(0, 0, 3, 0, 0);
    chk(res_data[0] == 16'hBEEF, "R8 unchanged", res_data[0], 16'hBEEF);

    // R12 concurrent test-and-set on one zero word
    conc_tas = 1;
    for (int p = 0; p < N; p++) issue(p, 2, 9, 0, 0);
    run();
    conc_tas = 0;
    begin
      int wins;
      wins = 0;
      for (int p = 0; p < N; p++) wins += res_flag[p];
      chk(wins == 1, "R12 winners", wins, 1);
    end
    // R3 release with store 0, then take again
    do1(2, 1, 9, 0, 0);
    do1(1, 2, 9, 0, 0);
    chk(res_flag[1] == 1, "R3 release", res_flag[1], 1);

    // R10 round-robin rotation
    do1(1, 0, 0, 0, 0);
    order.delete();
    for (int p = 0; p < N; p++) issue(p, 0, p, 0, 0);
    run();
    begin
      int exp_o [4] = '{2, 3, 0, 1};
      for (int k = 0; k < N; k++)
        chk(order[k] == exp_o[k], "R10 order", order[k], exp_o[k]);
    end

    // R6 / R9 concurrent fetch-and-add stays indivisible
    for (int p = 0; p < N; p++) issue(p, 3, 10, p + 1, 0);
    run();
    do1(0, 0, 10, 0, 0);
    chk(res_data[0] == 10, "R9 faa total", res_data[0], 10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule